// File: doc/BRIEF.md
# Effective Address Byte-Stream Decoder

This block sits behind an instruction fetch path and consumes, one byte per accepted handshake, the addressing bytes that follow an opcode: the ModR/M byte, an optional scale-index-base byte and a displacement of zero, one, two or four bytes. The address-size select, either 16-bit or 32-bit, is sampled together with the ModR/M byte. The block reads the eight general registers from a flat input vector, forms the effective address and presents it with a one-cycle result strobe. Alongside the address it reports the reg field of the ModR/M byte, a flag for register-direct operands and the total number of addressing bytes consumed.

Registers are numbered 0 to 7 in the order AX/EAX, CX/ECX, DX/EDX, BX/EBX, SP/ESP, BP/EBP, SI/ESI, DI/EDI. Register n occupies bits n*32+31 down to n*32 of the register vector. In 16-bit mode only the low 16 bits of each register take part. ModR/M is laid out as mod in bits 7:6, reg in 5:3 and r/m in 2:0. Multi-byte displacements arrive least significant byte first. Prefixes, segment bases and the opcode itself are handled elsewhere.

Top module: `eaStreamDecoder`

## Requirements
- R1: After reset `resValid` is 0 and `inReady` is 1, and the next accepted byte is taken as a ModR/M byte.
- R2: A ModR/M byte with mod=3 ends the operand at once: `regDirect`=1, `effAddr`=0, `byteCount`=1.
- R3: With `addr32`=0 the r/m codes 0..7 add BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX. mod=1 adds a sign-extended 8-bit displacement and mod=2 a 16-bit displacement. The sum wraps modulo 2^16, bits 31:16 of `effAddr` are 0, and no SIB byte is ever read.
- R4: With `addr32`=0, mod=0 and r/m=6, the address is the two-byte displacement alone.
- R5: With `addr32`=1 and r/m other than 4, the address is register r/m plus a displacement. The displacement is absent for mod=0, a sign-extended byte for mod=1 and four bytes for mod=2.
- R6: With `addr32`=1, mod=0 and r/m=5, the address is a four-byte displacement with no register added.
- R7: With `addr32`=1, mod≠3 and r/m=4, a SIB byte follows: scale in bits 7:6, index in 5:3, base in 2:0. The address is base + (index << scale) + displacement, so scale codes 0..3 multiply by 1, 2, 4 and 8.
- R8: A SIB index field of 4 adds no index term.
- R9: A SIB base field of 5 with mod=0 drops the base register and appends a four-byte displacement, while the index is still applied.
- R10: `resValid` is high for exactly one cycle, the cycle after the last addressing byte is accepted. `inReady` is 0 in that cycle, and `byteCount` equals 1 + SIB present + displacement length.
- R11: Cycles with `inValid` low consume nothing, whatever is on `inData`.
- R12: `regField` equals bits 5:3 of the ModR/M byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A byte is offered on `inData` |
| inData | input | 8 | Addressing byte |
| inReady | output | 1 | The block takes the offered byte this cycle |
| addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit; sampled with the ModR/M byte |
| regFile | input | 256 | Eight 32-bit register values, register n at bits n*32 upward |
| resValid | output | 1 | One-cycle result strobe |
| effAddr | output | 32 | Effective address |
| regField | output | 3 | reg field of the ModR/M byte |
| regDirect | output | 1 | Operand is a register, not memory |
| byteCount | output | 3 | Addressing bytes consumed for this operand |

## Verification
Random ModR/M, SIB and displacement bytes are sent in both address sizes with random register contents and random idle gaps carrying junk data. Each operand is compared against a bench model, which separates the displacement-length decisions from the register-sum decisions. Directed operands then isolate each exception: [BP] in 16-bit mode with a zero byte displacement against the disp16-only form, [ESP] through a SIB byte with no index, a no-base SIB with a scaled index, the disp32-only form and a negative byte displacement. A 16-bit case with BX and SI near 0xFFFF shows wrapping. A long stall mid-operand shows that idle cycles neither advance the parse nor raise the result strobe.

// File: rtl/eaPkg.sv
package eaPkg;
  localparam int REG_W     = 32;
  localparam int NUM_REGS  = 8;
  localparam int RIDX_W    = $clog2(NUM_REGS);
  localparam int MAX_DISP  = 4;
  localparam int DIDX_W    = $clog2(MAX_DISP);
  localparam int CNT_W     = 3;

  typedef enum logic [1:0] {
    ST_MODRM = 2'd0,
    ST_SIB   = 2'd1,
    ST_DISP  = 2'd2,
    ST_DONE  = 2'd3
  } eaState_e;

  typedef struct packed {
    logic ldModrm;
    logic ldSib;
    logic ldDisp;
  } eaStrobe_t;
endpackage

// File: rtl/eaControl.sv
module eaControl
  import eaPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             needSib,
  input  logic [CNT_W-1:0] modrmLen,
  input  logic [CNT_W-1:0] sibLen,
  input  logic             dispLast,
  output logic             inReady,
  output logic             resValid,
  output eaStrobe_t        strobe
);
  eaState_e state, stateNext;
  logic accept;

  assign inReady  = (state != ST_DONE);
  assign resValid = (state == ST_DONE);
  assign accept   = inValid && inReady;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_MODRM: if (accept) begin
        strobe.ldModrm = 1'b1;
        if (needSib)              stateNext = ST_SIB;
        else if (modrmLen != '0)  stateNext = ST_DISP;
        else                      stateNext = ST_DONE;
      end
      ST_SIB: if (accept) begin
        strobe.ldSib = 1'b1;
        stateNext = (sibLen != '0) ? ST_DISP : ST_DONE;
      end
      ST_DISP: if (accept) begin
        strobe.ldDisp = 1'b1;
        if (dispLast) stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_MODRM;
      default: stateNext = ST_MODRM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_MODRM;
    else       state <= stateNext;
  end

  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R10
  AST_NO_READY_IN_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !inReady); // R10
  AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> $past(inValid && inReady)); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && state != ST_DONE) |=> $stable(state)); // R11
endmodule

// File: rtl/eaDatapath.sv
module eaDatapath
  import eaPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [7:0]                inData,
  input  logic                      addr32,
  input  logic [NUM_REGS*REG_W-1:0] regFile,
  input  eaStrobe_t                 strobe,
  input  logic                      resValid,
  output logic                      needSib,
  output logic [CNT_W-1:0]          modrmLen,
  output logic [CNT_W-1:0]          sibLen,
  output logic                      dispLast,
  output logic [REG_W-1:0]          effAddr,
  output logic [RIDX_W-1:0]         regField,
  output logic                      regDirect,
  output logic [CNT_W-1:0]          byteCount
);
  logic [7:0]          modrmQ, sibQ;
  logic                mode32Q, hasSibQ;
  logic [CNT_W-1:0]    dispLenQ;
  logic [DIDX_W-1:0]   dispIdx;
  logic [8*MAX_DISP-1:0] dispQ;
  logic [REG_W-1:0]    regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    assign regs[g] = regFile[g*REG_W +: REG_W];
  end

  // Length and SIB decisions from the byte on the input.
  logic [1:0] inMod;
  logic [2:0] inRm;
  assign inMod = inData[7:6];
  assign inRm  = inData[2:0];

  always_comb begin
    unique case (inMod)
      2'd0: modrmLen = addr32 ? ((inRm == 3'd5) ? 3'd4 : 3'd0)
                              : ((inRm == 3'd6) ? 3'd2 : 3'd0);
      2'd1: modrmLen = 3'd1;
      2'd2: modrmLen = addr32 ? 3'd4 : 3'd2;
      default: modrmLen = 3'd0;
    endcase
  end

  assign needSib  = addr32 && (inMod != 2'd3) && (inRm == 3'd4);
  assign sibLen   = (modrmQ[7:6] == 2'd0 && inData[2:0] == 3'd5) ? 3'd4 : dispLenQ;
  assign dispLast = (({1'b0, dispIdx}) + 3'd1) == dispLenQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modrmQ   <= '0;
      sibQ     <= '0;
      mode32Q  <= 1'b0;
      hasSibQ  <= 1'b0;
      dispLenQ <= '0;
      dispIdx  <= '0;
      dispQ    <= '0;
    end else begin
      if (strobe.ldModrm) begin
        modrmQ   <= inData;
        mode32Q  <= addr32;
        hasSibQ  <= needSib;
        dispLenQ <= modrmLen;
        dispIdx  <= '0;
        dispQ    <= '0;
      end
      if (strobe.ldSib) begin
        sibQ     <= inData;
        dispLenQ <= sibLen;
      end
      if (strobe.ldDisp) begin
        dispQ[{dispIdx, 3'b000} +: 8] <= inData;
        dispIdx <= dispIdx + 1'b1;
      end
    end
  end

  // Address formation from latched fields.
  logic [1:0] qMod, qScale;
  logic [2:0] qRm, qIdx, qBase;
  assign qMod   = modrmQ[7:6];
  assign qRm    = modrmQ[2:0];
  assign qScale = sibQ[7:6];
  assign qIdx   = sibQ[5:3];
  assign qBase  = sibQ[2:0];

  logic [REG_W-1:0] dispExt, ea32, baseTerm, idxTerm;
  logic [15:0]      pair16, ea16;

  assign dispExt = (dispLenQ == 3'd1) ? {{(REG_W-8){dispQ[7]}}, dispQ[7:0]} : dispQ;

  always_comb begin
    baseTerm = '0;
    idxTerm  = '0;
    if (hasSibQ) begin
      baseTerm = (qMod == 2'd0 && qBase == 3'd5) ? '0 : regs[qBase];
      idxTerm  = (qIdx == 3'd4) ? '0 : (regs[qIdx] << qScale);
    end else if (!(qMod == 2'd0 && qRm == 3'd5)) begin
      baseTerm = regs[qRm];
    end
  end
  assign ea32 = baseTerm + idxTerm + dispExt;

  always_comb begin
    unique case (qRm)
      3'd0: pair16 = regs[3][15:0] + regs[6][15:0];
      3'd1: pair16 = regs[3][15:0] + regs[7][15:0];
      3'd2: pair16 = regs[5][15:0] + regs[6][15:0];
      3'd3: pair16 = regs[5][15:0] + regs[7][15:0];
      3'd4: pair16 = regs[6][15:0];
      3'd5: pair16 = regs[7][15:0];
      3'd6: pair16 = (qMod == 2'd0) ? 16'd0 : regs[5][15:0];
      default: pair16 = regs[3][15:0];
    endcase
  end
  assign ea16 = pair16 + dispExt[15:0];

  assign regDirect = (qMod == 2'd3);
  assign regField  = modrmQ[5:3];
  assign effAddr   = regDirect ? '0 : (mode32Q ? ea32 : {{(REG_W-16){1'b0}}, ea16});
  assign byteCount = 3'd1 + {2'b00, hasSibQ} + dispLenQ;

  AST_DIRECT_ONE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && regDirect) |-> (byteCount == 3'd1 && effAddr == '0)); // R2
  AST_NARROW_NO_SIB: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !mode32Q) |-> (byteCount <= 3'd3 && effAddr[31:16] == 16'd0)); // R3
  AST_WIDE_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> byteCount <= 3'd6); // R10
  AST_SIB_ONLY_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldSib |-> mode32Q); // R7
endmodule

// File: rtl/eaStreamDecoder.sv
module eaStreamDecoder
  import eaPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [7:0]                inData,
  output logic                      inReady,
  input  logic                      addr32,
  input  logic [NUM_REGS*REG_W-1:0] regFile,
  output logic                      resValid,
  output logic [REG_W-1:0]          effAddr,
  output logic [RIDX_W-1:0]         regField,
  output logic                      regDirect,
  output logic [CNT_W-1:0]          byteCount
);
  eaStrobe_t        strobe;
  logic             needSib, dispLast;
  logic [CNT_W-1:0] modrmLen, sibLen;

  eaControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .needSib  (needSib),
    .modrmLen (modrmLen),
    .sibLen   (sibLen),
    .dispLast (dispLast),
    .inReady  (inReady),
    .resValid (resValid),
    .strobe   (strobe)
  );

  eaDatapath uPath (
    .clk       (clk),
    .rstN      (rstN),
    .inData    (inData),
    .addr32    (addr32),
    .regFile   (regFile),
    .strobe    (strobe),
    .resValid  (resValid),
    .needSib   (needSib),
    .modrmLen  (modrmLen),
    .sibLen    (sibLen),
    .dispLast  (dispLast),
    .effAddr   (effAddr),
    .regField  (regField),
    .regDirect (regDirect),
    .byteCount (byteCount)
  );
endmodule

// File: tb/sim_eaStreamDecoder.sv
module sim_eaStreamDecoder;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [7:0]   inData = '0;
  logic         inReady;
  logic         addr32 = 1'b0;
  logic [255:0] regFile = '0;
  logic         resValid;
  logic [31:0]  effAddr;
  logic [2:0]   regField;
  logic         regDirect;
  logic [2:0]   byteCount;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  eaStreamDecoder u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .addr32(addr32), .regFile(regFile), .resValid(resValid), .effAddr(effAddr),
    .regField(regField), .regDirect(regDirect), .byteCount(byteCount)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rg(input logic [255:0] rf, input logic [2:0] n);
    return rf[n*32 +: 32];
  endfunction

  // Returns {count[2:0], ea[31:0]} for bytes packed little-first in b.
  function automatic logic [34:0] model(input logic m32, input logic [47:0] b,
                                        input logic [255:0] rf);
    logic [1:0] md; logic [2:0] rm; logic [7:0] sb;
    logic [31:0] ea, disp; int pos, dlen;
    md = b[7:6]; rm = b[2:0]; pos = 1; ea = 0; dlen = 0;
    if (md == 2'd3) return {3'd1, 32'd0};
    if (m32) begin
      if (rm == 3'd4) begin
        sb = b[15:8]; pos = 2;
        ea = ((md == 0 && sb[2:0] == 5) ? 32'd0 : rg(rf, sb[2:0]))
           + ((sb[5:3] == 4) ? 32'd0 : (rg(rf, sb[5:3]) * (32'd1 << sb[7:6])));
        dlen = (md == 1) ? 1 : (md == 2) ? 4 : ((sb[2:0] == 5) ? 4 : 0);
      end else if (md == 0 && rm == 5) begin
        dlen = 4;
      end else begin
        ea = rg(rf, rm);
        dlen = (md == 1) ? 1 : (md == 2) ? 4 : 0;
      end
    end else begin
      case (rm)
        0: ea = rg(rf, 3) + rg(rf, 6);
        1: ea = rg(rf, 3) + rg(rf, 7);
        2: ea = rg(rf, 5) + rg(rf, 6);
        3: ea = rg(rf, 5) + rg(rf, 7);
        4: ea = rg(rf, 6);
        5: ea = rg(rf, 7);
        6: ea = (md == 0) ? 32'd0 : rg(rf, 5);
        default: ea = rg(rf, 3);
      endcase
      dlen = (md == 1) ? 1 : (md == 2) ? 2 : ((rm == 6) ? 2 : 0);
    end
    disp = 0;
    for (int i = 0; i < dlen; i++) disp[i*8 +: 8] = b[(pos+i)*8 +: 8];
    if (dlen == 1) disp = {{24{disp[7]}}, disp[7:0]};
    ea = ea + disp;
    if (!m32) ea = {16'd0, ea[15:0]};
    return {3'(pos + dlen), ea};
  endfunction

  task automatic runOp(input logic m32, input logic [47:0] b, input int maxGap,
                       input string req);
    logic [34:0] exp;
    int cnt;
    exp = model(m32, b, regFile);
    cnt = int'(exp[34:32]);
    for (int i = 0; i < cnt; i++) begin
      int gap;
      gap = (maxGap > 0) ? int'($urandom_range(maxGap, 0)) : 0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        inValid = 1'b0;
        inData  = 8'($urandom);        // junk while idle (R11)
        addr32  = 1'($urandom);
      end
      @(negedge clk);
      inValid = 1'b1;
      inData  = b[i*8 +: 8];
      addr32  = m32;
    end
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R10 strobe"}, {31'd0, resValid}, 32'd1);
    check({req, " R10 ready low"}, {31'd0, inReady}, 32'd0);
    check({req, " ea"}, effAddr, exp[31:0]);
    check({req, " R10 count"}, {29'd0, byteCount}, {29'd0, exp[34:32]});
    check({req, " R12 reg"}, {29'd0, regField}, {29'd0, b[5:3]});
    check({req, " R2 direct"}, {31'd0, regDirect}, {31'd0, (b[7:6] == 2'd3)});
    @(negedge clk);
    check({req, " R10 single pulse"}, {31'd0, resValid}, 32'd0);
  endtask

  task automatic randRegs();
    for (int i = 0; i < 8; i++) regFile[i*32 +: 32] = $urandom;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    randRegs();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 strobe after reset", {31'd0, resValid}, 32'd0);
    check("R1 ready after reset", {31'd0, inReady}, 32'd1);

    // Directed corner cases
    runOp(1'b1, 48'hC1, 0, "R2 reg direct 32");
    runOp(1'b0, 48'hDA, 1, "R2 reg direct 16");
    runOp(1'b0, 48'h12_34_06, 0, "R4 disp16 only");
    runOp(1'b0, 48'h00_46, 0, "R3 BP plus zero disp8");
    runOp(1'b1, 48'h11_22_33_44_05, 0, "R6 disp32 only");
    runOp(1'b1, 48'h24_04, 0, "R8 ESP via SIB no index");
    runOp(1'b1, 48'h78_56_34_12_B5_04, 0, "R9 no base scaled index");
    runOp(1'b1, 48'h80_45, 0, "R5 negative disp8");
    runOp(1'b1, 48'hFC_5C_44, 0, "R7 base index scale2 disp8");
    regFile[3*32 +: 32] = 32'h0000_FFF0;
    regFile[6*32 +: 32] = 32'hABCD_0020;
    runOp(1'b0, 48'h00_10_80, 0, "R3 wrap mod 2^16");

    // R11: long stall mid-operand
    @(negedge clk); inValid = 1'b1; inData = 8'h84; addr32 = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); inValid = 1'b0; inData = 8'($urandom);
      check("R11 no strobe while idle", {31'd0, resValid}, 32'd0);
    end
    // SIB 0x00 (base EAX, index EAX, scale 1), disp32
    begin
      logic [47:0] rest;
      logic [34:0] exp;
      rest = 48'h01_00_00_00_00_84;
      exp  = model(1'b1, rest, regFile);
      for (int i = 1; i < 6; i++) begin
        @(negedge clk); inValid = 1'b1; inData = rest[i*8 +: 8];
      end
      @(negedge clk); inValid = 1'b0;
      check("R11 stalled operand strobe", {31'd0, resValid}, 32'd1);
      check("R11 stalled operand ea", effAddr, exp[31:0]);
    end

    // Constrained random
    for (int n = 0; n < 400; n++) begin
      logic [47:0] b;
      logic m;
      if (n % 25 == 0) randRegs();
      b = {$urandom, $urandom};
      m = 1'($urandom);
      runOp(m, b[47:0], 2, m ? "R5 R7 random 32" : "R3 random 16");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule